// File: doc/BRIEF.md
# Code Phase Slew Controller

This block shifts the local code replica of one correlator channel by a relative amount of code phase. Software writes a slew amount counted in half code chips. Writing the value 2 moves the replica by one whole chip. The write has no effect of its own. The amount waits until the next dump strobe, and from that point the block holds back that many half-chip clock enables from the code generator. The replica therefore ends up late by the requested amount, measured from wherever it stood.

While enables are being held back, the channel's integrate-and-dump accumulator is kept in reset. Integration restarts only once the slew is complete. Each written amount is used once. A second shift, even one of the same size, needs a new write. A write that arrives while a slew is running waits as the pending amount and is applied at a later dump.

Top module: `slew_ctl`

## Requirements
- R1: After a synchronous reset, `code_ce`, `slew_busy` and `acc_clr` are all 0.
- R2: When no slew is running, every cycle with `half_tick` high is followed one cycle later by a single-cycle `code_ce` pulse.
- R3: A write through `wr_en`/`wr_amount` does not suppress any `code_ce` pulse before the next `dump` strobe.
- R4: After a `dump` that takes a pending nonzero amount N, in half-chip units (2 equals one chip), exactly N `half_tick` pulses produce no `code_ce` pulse. All later pulses pass.
- R5: `slew_busy` rises in the cycle after the `dump` that starts a slew. It falls in the cycle after the last suppressed `half_tick`. `acc_clr` is high in exactly the same cycles as `slew_busy`.
- R6: A pending amount is used by one dump only. A later `dump` with no new write suppresses nothing and does not raise `slew_busy`.
- R7: A pending amount of 0 is used by the next dump without raising `slew_busy` or `acc_clr` and without suppressing any `code_ce`.
- R8: A write made while `slew_busy` is high becomes the pending amount. A `dump` seen while `slew_busy` is high is ignored. The pending amount is applied at the first `dump` after `slew_busy` falls.
- R9: A `dump` with no pending amount, for example the first one after reset, suppresses nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the slew amount |
| wr_amount | input | AMT_W | Slew amount in half-chip units |
| dump | input | 1 | Integrate-and-dump strobe, one cycle |
| half_tick | input | 1 | Half-chip clock enable from the code clock source |
| code_ce | output | 1 | Gated half-chip enable to the code generator, registered |
| acc_clr | output | 1 | Holds the accumulator in reset during a slew, registered |
| slew_busy | output | 1 | High while a slew is in progress, registered |

## Verification
The main function is exercised with every amount that a 3-bit field can hold. Each amount is driven with half-tick enables on every cycle, every second cycle and every third cycle. The number of lost enables must equal the amount in all cases, which separates counting half-ticks from counting clock cycles. Quiet windows after a write, and repeat dumps without a write, show that a slew waits for a dump and that each amount is used only once. A write followed by a dump during a running slew shows the pending path apart from a restart. In that case the first slew loses exactly its own amount and the second amount is lost only at the dump after that.

// File: rtl/slew_pkg.sv
package slew_pkg;
  // Pending slew request as held between the write port and the next dump.
  typedef struct packed {
    logic       valid;
    logic [7:0] amount;
  } slew_req_t;

  localparam int unsigned MAX_AMT_W = 8;
endpackage

// File: rtl/slew_pending.sv
module slew_pending #(
  parameter int unsigned AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AMT_W-1:0] wr_amount,
  input  logic             take,
  output logic             valid,
  output logic [AMT_W-1:0] amount
);
  // A write always wins over a take in the same cycle: the old request
  // is consumed by the dump and the new one waits for the next dump.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      amount <= '0;
    end else if (wr_en) begin
      valid  <= 1'b1;
      amount <= wr_amount;
    end else if (take) begin
      valid  <= 1'b0;
    end
  end

  // R6: a take with no write leaves nothing pending
  p_take_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_en) |=> !valid);
endmodule

// File: rtl/slew_counter.sv
module slew_counter #(
  parameter int unsigned AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AMT_W-1:0] load,
  input  logic             half_tick,
  output logic             busy,
  output logic             swallow
);
  logic [AMT_W-1:0] remain;

  // The incoming tick is removed whenever a slew is underway.
  assign swallow = busy && half_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= load;
    end else if (swallow) begin
      remain <= remain - 1'b1;
      if (remain == {{(AMT_W-1){1'b0}}, 1'b1}) busy <= 1'b0;
    end
  end

  // R4: the count never underflows while a slew is running
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (remain != '0));
  // R5: a slew only finishes on a consumed half tick
  p_end_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(half_tick));
  // R4: the remaining count is held between half ticks
  p_hold_count_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !half_tick && !start) |=> $stable(remain));
endmodule

// File: rtl/slew_gate.sv
module slew_gate (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic swallow,
  input  logic busy_next,
  output logic code_ce,
  output logic acc_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_ce <= 1'b0;
      acc_clr <= 1'b0;
    end else begin
      code_ce <= half_tick && !swallow;
      acc_clr <= busy_next;
    end
  end

  // R2: an output enable always traces back to an input tick
  p_ce_from_tick_r2: assert property (@(posedge clk) disable iff (rst)
    code_ce |-> $past(half_tick));
  // R4: a suppressed tick produces no output enable
  p_swallow_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    swallow |=> !code_ce);
endmodule

// File: rtl/slew_ctl.sv
module slew_ctl #(
  parameter int unsigned AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AMT_W-1:0] wr_amount,
  input  logic             dump,
  input  logic             half_tick,
  output logic             code_ce,
  output logic             acc_clr,
  output logic             slew_busy
);
  import slew_pkg::*;

  localparam logic [AMT_W-1:0] ZERO_AMT = '0;

  initial begin
    if (AMT_W < 1 || AMT_W > MAX_AMT_W)
      $error("slew_ctl: AMT_W out of range");
  end

  logic             pend_valid;
  logic [AMT_W-1:0] pend_amt;
  logic             take;
  logic             start;
  logic             busy;
  logic             swallow;
  logic             busy_next;

  // A dump is only honoured between slews.
  assign take  = dump && !busy && pend_valid;
  assign start = take && (pend_amt != ZERO_AMT);
  // Next-cycle busy, used to keep acc_clr aligned with the busy flag.
  assign busy_next = start ||
                     (busy && !(swallow && (u_cnt.remain == {{(AMT_W-1){1'b0}}, 1'b1})));

  slew_pending #(.AMT_W(AMT_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_amount (wr_amount),
    .take      (take),
    .valid     (pend_valid),
    .amount    (pend_amt)
  );

  slew_counter #(.AMT_W(AMT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (pend_amt),
    .half_tick (half_tick),
    .busy      (busy),
    .swallow   (swallow)
  );

  slew_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick),
    .swallow   (swallow),
    .busy_next (busy_next),
    .code_ce   (code_ce),
    .acc_clr   (acc_clr)
  );

  assign slew_busy = busy;

  // R5: a slew begins only on a dump
  p_start_on_dump_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(dump));
  // R5: accumulator reset and busy flag agree every cycle
  p_clr_matches_busy_r5: assert property (@(posedge clk) disable iff (rst)
    acc_clr == busy);
  // R8: a dump during a slew does not restart it
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && dump && !swallow) |=> busy);
  // R7: a zero amount never starts a slew
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (take && pend_amt == ZERO_AMT && !busy) |=> !busy);
endmodule

// File: tb/test_slew_ctl.sv
module test_slew_ctl;
  localparam int unsigned AMT_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             wr_en;
  logic [AMT_W-1:0] wr_amount;
  logic             dump;
  logic             half_tick;
  logic             code_ce;
  logic             acc_clr;
  logic             slew_busy;

  int checks = 0;
  int errors = 0;
  int sent, got, busy_cycles, clr_mismatch, phase, period;
  logic prev_dump;
  logic busy_after_dump;
  bit done = 0;

  always #5 clk = ~clk;

  slew_ctl #(.AMT_W(AMT_W)) i_slew_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_amount (wr_amount),
    .dump      (dump),
    .half_tick (half_tick),
    .code_ce   (code_ce),
    .acc_clr   (acc_clr),
    .slew_busy (slew_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample outputs at the falling edge, then drive inputs for the next rise.
  task automatic step(input logic w, input int amt, input logic d, input logic tick_on);
    @(negedge clk);
    if (code_ce) got++;
    if (slew_busy) busy_cycles++;
    if (acc_clr !== slew_busy) clr_mismatch++;
    if (prev_dump) busy_after_dump = slew_busy;
    wr_en     = w;
    wr_amount = AMT_W'(amt);
    dump      = d;
    half_tick = tick_on && (phase % period == 0);
    if (half_tick) sent++;
    phase++;
    prev_dump = d;
  endtask

  task automatic clear_counts();
    sent = 0; got = 0; busy_cycles = 0; clr_mismatch = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b1);
  endtask

  task automatic flush();
    step(1'b0, 0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_amount = '0; dump = 0; half_tick = 0;
    phase = 0; period = 1; prev_dump = 0; busy_after_dump = 0;
    clear_counts();
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    check("R1 code_ce", int'(code_ce), 0);
    check("R1 busy", int'(slew_busy), 0);
    check("R1 acc_clr", int'(acc_clr), 0);
    @(negedge clk);
    rst = 1'b0;

    // R9: dump with nothing pending after reset
    clear_counts();
    run(3);
    step(1'b0, 0, 1'b1, 1'b1);
    run(6); flush();
    check("R9 lost ticks", sent - got, 0);
    check("R9 busy cycles", busy_cycles, 0);

    for (int p = 1; p <= 3; p++) begin
      for (int a = 0; a < (1 << AMT_W); a++) begin
        period = p;
        // R3 / R2: write, then ticks with no dump lose nothing
        clear_counts();
        step(1'b1, a, 1'b0, 1'b1);
        run(6); flush();
        check("R3 no slew before dump", sent - got, 0);
        check("R2 passthrough count", got, sent);
        // R4 / R7: dump applies exactly a half ticks of slew
        clear_counts();
        step(1'b0, 0, 1'b1, 1'b1);
        run(a * p + 6); flush();
        check(a == 0 ? "R7 zero slew loss" : "R4 lost ticks", sent - got, a);
        check("R5 busy after dump", int'(busy_after_dump), (a != 0) ? 1 : 0);
        check("R5 acc_clr tracks busy", clr_mismatch, 0);
        if (p == 1) check("R5 busy length", busy_cycles, a);
        // R6: second dump without write does nothing
        clear_counts();
        step(1'b0, 0, 1'b1, 1'b1);
        run(a * p + 6); flush();
        check("R6 one-shot", sent - got, 0);
        check("R6 no busy", busy_cycles, 0);
      end
    end

    // R8: write and dump during a running slew
    period = 1;
    clear_counts();
    step(1'b1, 5, 1'b0, 1'b1);
    step(1'b0, 0, 1'b1, 1'b1);
    step(1'b1, 2, 1'b0, 1'b1);
    step(1'b0, 0, 1'b1, 1'b1);
    run(12); flush();
    check("R8 first slew only", sent - got, 5);
    check("R8 busy length", busy_cycles, 5);
    clear_counts();
    step(1'b0, 0, 1'b1, 1'b1);
    run(8); flush();
    check("R8 pending applied", sent - got, 2);
    clear_counts();
    step(1'b0, 0, 1'b1, 1'b1);
    run(8); flush();
    check("R8 pending consumed", sent - got, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule